// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Loader

This block takes programming words for a frequency synthesizer over a three-wire serial link: a data line, a shift clock and a latch enable. All three lines are brought into the system clock domain through two-flop synchronisers. The block detects edges there and shifts the data into a 19-bit register on each shift-clock rise. A rising latch enable copies the register into one of two configuration banks. The bit that arrived last decides which bank is written.

The reference bank holds a 14-bit reference division ratio and four single-bit controls: prescaler modulus select, phase-detector polarity, lock-detect/output select and charge-pump current select. The main bank holds the 7-bit swallow count A and the 11-bit program count N. A reference word whose ratio is below 3 is discarded as a whole. Every accepted latch raises a one-cycle update strobe for the bank that changed. The dividers, the phase detector and the analog parts are outside this block.

Top module: `ser_synth_loader`

## Requirements
- R1: The three serial inputs are sampled by two flip-flops in the `clk_i` domain. A change on a pin takes effect at the third rising `clk_i` edge that sees the new level, counting the edge that first samples it. Each pin level must be held for at least three `clk_i` cycles.
- R2: Each rising edge of `ser_clk_i` shifts `ser_dat_i` into the register. The first bit sent of a 19-bit word ends in position 19, and the last bit sent (the control bit) ends in position 1.
- R3: Shifting without a latch edge never changes any configuration output or strobe.
- R4: A latch edge with control bit 1 loads the reference bank. Positions 2..15 give `ref_ratio_o`, with position 2 as the LSB. Position 16 gives `presc_sel_o` (0 = 64/65, 1 = 128/129), 17 gives `phase_pol_o`, 18 gives `lock_sel_o` and 19 gives `cp_sel_o`. The main outputs do not change.
- R5: A latch edge with control bit 0 loads `main_a_o` from positions 2..8 (position 2 is the LSB) and `main_n_o` from positions 9..19 (position 9 is the LSB). The reference outputs do not change.
- R6: A reference word whose ratio field is below 3 is rejected. No output changes and no strobe is raised.
- R7: Each accepted latch raises the strobe of the written bank (`ref_upd_o` or `main_upd_o`) for exactly one `clk_i` cycle. The strobe rises in the same cycle as the new bank values.
- R8: If a shift-clock rise and a latch rise are detected in the same cycle, the latch takes the word held before that shift, and the new bit is still shifted in.
- R9: After reset `ref_ratio_o` is 3. All other outputs, the strobes and the shift register are 0.
- R10: Only a rising latch edge loads a bank. Shifting while the latch enable stays high loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Latch enable (asynchronous) |
| ref_ratio_o | output | 14 | Reference division ratio |
| presc_sel_o | output | 1 | Prescaler modulus select |
| phase_pol_o | output | 1 | Phase detector polarity |
| lock_sel_o | output | 1 | Lock-detect / divider output select |
| cp_sel_o | output | 1 | Charge-pump current select |
| main_a_o | output | 7 | Swallow count A |
| main_n_o | output | 11 | Program count N |
| ref_upd_o | output | 1 | One-cycle reference bank update strobe |
| main_upd_o | output | 1 | One-cycle main bank update strobe |

## Verification
A shift and a latch can fall in the same system cycle. This happens when the shift clock and the latch enable rise on one bench edge: both pass through synchronisers of equal depth, so their edges are detected together. The bench first sends a full main word. It then raises the data, the shift clock and the latch enable at once. It checks that the main bank received the complete earlier word. It then latches again with no shift and checks that the bank now holds that word moved one place with the extra bit at position 1.

// File: rtl/synth_ld_pkg.sv
package synth_ld_pkg;
  localparam int unsigned REF_W   = 14;
  localparam int unsigned SWAL_W  = 7;
  localparam int unsigned PROG_W  = 11;
  localparam int unsigned REF_MIN = 3;
  localparam int unsigned FLAG_N  = 4;
  localparam int unsigned WORD_W  = 1 + REF_W + FLAG_N;

  typedef struct packed {
    logic             cp_sel;
    logic             lock_sel;
    logic             phase_pol;
    logic             presc_sel;
    logic [REF_W-1:0] ratio;
  } ref_cfg_t;

  typedef struct packed {
    logic [PROG_W-1:0] n;
    logic [SWAL_W-1:0] a;
  } main_cfg_t;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg1_q[g] <= 1'b0;
        stg2_q[g] <= 1'b0;
      end else begin
        stg1_q[g] <= d_i[g];
        stg2_q[g] <= stg1_q[g];
      end
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int unsigned SR_W = 19
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_i,
  input  logic            dat_i,
  input  logic            le_i,
  output logic [SR_W-1:0] word_o,
  output logic            le_rise_o
);
  logic            sclk_prev_q, le_prev_q;
  logic            sclk_rise;
  logic [SR_W-1:0] sr_q, sr_d;

  always_comb begin
    sclk_rise = sclk_i & ~sclk_prev_q;
    le_rise_o = le_i & ~le_prev_q;
    sr_d      = sr_q;
    if (sclk_rise) sr_d = {sr_q[SR_W-2:0], dat_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      le_prev_q   <= 1'b0;
      sr_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_i;
      le_prev_q   <= le_i;
      sr_q        <= sr_d;
    end
  end

  assign word_o = sr_q;

  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && !sclk_prev_q) |=> sr_q == {$past(sr_q[SR_W-2:0]), $past(dat_i)}); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_i && !sclk_prev_q) |=> $stable(sr_q)); // R2
  AST_LE_SINGLE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_rise_o |=> !le_rise_o); // R10
endmodule

// File: rtl/bank_latch.sv
module bank_latch
  import synth_ld_pkg::*;
#(
  parameter int unsigned R_MIN = REF_MIN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_rise_i,
  input  logic [WORD_W-1:0] word_i,
  output ref_cfg_t          ref_o,
  output main_cfg_t         main_o,
  output logic              ref_upd_o,
  output logic              main_upd_o
);
  localparam logic [REF_W-1:0] R_MIN_V = REF_W'(R_MIN);

  ref_cfg_t  ref_q, ref_d, ref_new;
  main_cfg_t main_q, main_d, main_new;
  logic      ref_upd_q, main_upd_q;
  logic      ref_ld, main_ld;

  always_comb begin
    ref_new  = ref_cfg_t'(word_i[WORD_W-1:1]);
    main_new = main_cfg_t'(word_i[WORD_W-1:1]);
    ref_ld   = le_rise_i & word_i[0] & (ref_new.ratio >= R_MIN_V);
    main_ld  = le_rise_i & ~word_i[0];
    ref_d    = ref_ld  ? ref_new  : ref_q;
    main_d   = main_ld ? main_new : main_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q       <= '0;
      ref_q.ratio <= R_MIN_V;
      main_q      <= '0;
      ref_upd_q   <= 1'b0;
      main_upd_q  <= 1'b0;
    end else begin
      ref_q      <= ref_d;
      main_q     <= main_d;
      ref_upd_q  <= ref_ld;
      main_upd_q <= main_ld;
    end
  end

  assign ref_o      = ref_q;
  assign main_o     = main_q;
  assign ref_upd_o  = ref_upd_q;
  assign main_upd_o = main_upd_q;

  AST_HOLD_WITHOUT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_rise_i |=> $stable(ref_q) && $stable(main_q) && !ref_upd_q && !main_upd_q); // R3
  AST_REF_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_q.ratio >= R_MIN_V); // R6
  AST_REJECT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise_i && word_i[0] && word_i[REF_W:1] < R_MIN_V) |=> $stable(ref_q) && !ref_upd_q); // R6
  AST_MAIN_SPARES_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise_i && !word_i[0]) |=> $stable(ref_q) && main_upd_q); // R5
  AST_REF_SPARES_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_rise_i && word_i[0]) |=> $stable(main_q)); // R4
  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ref_upd_q, main_upd_q})); // R7
  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_upd_q || main_upd_q) |=> !ref_upd_q && !main_upd_q); // R7
endmodule

// File: rtl/ser_synth_loader.sv
module ser_synth_loader
  import synth_ld_pkg::*;
#(
  parameter int unsigned R_MIN = REF_MIN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_le_i,
  output logic [REF_W-1:0]  ref_ratio_o,
  output logic              presc_sel_o,
  output logic              phase_pol_o,
  output logic              lock_sel_o,
  output logic              cp_sel_o,
  output logic [SWAL_W-1:0] main_a_o,
  output logic [PROG_W-1:0] main_n_o,
  output logic              ref_upd_o,
  output logic              main_upd_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word;
  logic              le_rise;
  ref_cfg_t          ref_cfg;
  main_cfg_t         main_cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  ser_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   ({ser_le_i, ser_dat_i, ser_clk_i}),
    .q_o   (pins_s)
  );

  ser_shift #(.SR_W(WORD_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .sclk_i   (pins_s[0]),
    .dat_i    (pins_s[1]),
    .le_i     (pins_s[2]),
    .word_o   (word),
    .le_rise_o(le_rise)
  );

  bank_latch #(.R_MIN(R_MIN)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .le_rise_i (le_rise),
    .word_i    (word),
    .ref_o     (ref_cfg),
    .main_o    (main_cfg),
    .ref_upd_o (ref_upd_o),
    .main_upd_o(main_upd_o)
  );

  assign ref_ratio_o = ref_cfg.ratio;
  assign presc_sel_o = ref_cfg.presc_sel;
  assign phase_pol_o = ref_cfg.phase_pol;
  assign lock_sel_o  = ref_cfg.lock_sel;
  assign cp_sel_o    = ref_cfg.cp_sel;
  assign main_a_o    = main_cfg.a;
  assign main_n_o    = main_cfg.n;
endmodule

// File: tb/ser_synth_loader_tb_top.sv
`timescale 1ns/1ps
module ser_synth_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n, sclk, sdat, sle;
  logic [13:0] ref_ratio;
  logic presc, phase, lsel, cps, ref_upd, main_upd;
  logic [6:0]  main_a;
  logic [10:0] main_n;

  int checks = 0, errors = 0, nref = 0, nmain = 0;
  bit done = 0;

  logic [13:0] e_r;
  logic e_ps, e_ph, e_ls, e_cp;
  logic [6:0]  e_a;
  logic [10:0] e_n;

  always #4 clk = ~clk;

  ser_synth_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_le_i(sle),
    .ref_ratio_o(ref_ratio), .presc_sel_o(presc), .phase_pol_o(phase), .lock_sel_o(lsel),
    .cp_sel_o(cps), .main_a_o(main_a), .main_n_o(main_n), .ref_upd_o(ref_upd),
    .main_upd_o(main_upd)
  );

  always @(negedge clk) begin
    if (ref_upd)  nref++;
    if (main_upd) nmain++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " ratio"}, 32'(ref_ratio), 32'(e_r));
    check({tag, " flags"}, {28'd0, cps, lsel, phase, presc}, {28'd0, e_cp, e_ls, e_ph, e_ps});
    check({tag, " A"}, 32'(main_a), 32'(e_a));
    check({tag, " N"}, 32'(main_n), 32'(e_n));
  endtask

  function automatic logic [18:0] mk_ref(input logic [13:0] r, input logic [3:0] f);
    return {f[3], f[2], f[1], f[0], r, 1'b1};
  endfunction

  function automatic logic [18:0] mk_main(input logic [6:0] a, input logic [10:0] n);
    return {n, a, 1'b0};
  endfunction

  task automatic model_apply(input logic [18:0] w, output bit er, output bit em);
    er = 0; em = 0;
    if (w[0]) begin
      if (w[14:1] >= 14'd3) begin
        e_r = w[14:1]; e_ps = w[15]; e_ph = w[16]; e_ls = w[17]; e_cp = w[18]; er = 1;
      end
    end else begin
      e_a = w[7:1]; e_n = w[18:8]; em = 1;
    end
  endtask

  task automatic send_bits(input logic [18:0] w);
    for (int i = 18; i >= 0; i--) begin
      @(negedge clk); sdat = w[i];
      repeat (3) @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic latch_pulse(input bit er, input bit em, input string tag);
    @(negedge clk); sle = 1'b1;
    repeat (2) @(negedge clk);
    check({tag, " R7 strobe early"}, {30'd0, ref_upd, main_upd}, 32'd0);
    @(negedge clk);
    check({tag, " R7 strobe on R1 cycle"}, {30'd0, ref_upd, main_upd}, {30'd0, er, em});
    @(negedge clk);
    check({tag, " R7 strobe one cycle"}, {30'd0, ref_upd, main_upd}, 32'd0);
    sle = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_word(input logic [18:0] w, input string tag);
    bit er, em;
    send_bits(w);
    check_all({tag, " R3 after shift"});
    model_apply(w, er, em);
    latch_pulse(er, em, tag);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit er, em;
    logic [18:0] w, w2;
    int r0, m0;
    rst_n = 1'b0; sclk = 1'b0; sdat = 1'b0; sle = 1'b0;
    e_r = 14'd3; e_ps = 0; e_ph = 0; e_ls = 0; e_cp = 0; e_a = '0; e_n = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R9 reset");
    check("R9 reset strobes", {30'd0, ref_upd, main_upd}, 32'd0);

    // R4 / R6: low ratios and every flag pattern
    for (int r = 0; r < 32; r++)
      do_word(mk_ref(14'(r), 4'(r)), (r < 3) ? "R6 reject" : "R4 ref sweep");
    // R4: walking one across the ratio field
    for (int b = 0; b < 14; b++)
      do_word(mk_ref(14'(1) << b, 4'(b)), "R4 ratio walk");
    // R6: rejected after a good value keeps it
    do_word(mk_ref(14'd16383, 4'hF), "R4 max ratio");
    do_word(mk_ref(14'd2, 4'h0), "R6 reject keeps");
    // R5: full swallow range, arithmetic N
    for (int a = 0; a < 128; a++)
      do_word(mk_main(7'(a), 11'((a * 37 + 5) % 2048)), "R5 main sweep");
    for (int b = 0; b < 11; b++)
      do_word(mk_main(7'(b * 9), 11'(1) << b), "R5 N walk");

    // R10: latch held high while another word shifts
    send_bits(mk_main(7'd11, 11'd222));
    model_apply(mk_main(7'd11, 11'd222), er, em);
    @(negedge clk); sle = 1'b1;
    repeat (8) @(negedge clk);
    r0 = nref; m0 = nmain;
    send_bits(mk_ref(14'd999, 4'h5));
    check("R10 no strobe while high", 32'(nref + nmain), 32'(r0 + m0));
    check_all("R10 held high");
    sle = 1'b0;
    repeat (4) @(negedge clk);
    model_apply(mk_ref(14'd999, 4'h5), er, em);
    latch_pulse(er, em, "R10 new edge");
    check_all("R10 new edge");

    // R8: shift and latch edges in the same cycle
    w = mk_main(7'h2B, 11'h5A3);
    send_bits(w);
    @(negedge clk); sdat = 1'b1; sclk = 1'b1; sle = 1'b1;
    repeat (3) @(negedge clk);
    model_apply(w, er, em);
    check("R8 strobe on coincident", {30'd0, ref_upd, main_upd}, 32'd1);
    repeat (2) @(negedge clk); sclk = 1'b0; sle = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R8 old word latched");
    w2 = {w[17:0], 1'b1};
    model_apply(w2, er, em);
    latch_pulse(er, em, "R8 shifted word");
    check_all("R8 shifted word");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule